// File: doc/BRIEF.md
# Address-Threshold Write Protect Controller

This block decides whether each decoded command to a 256-word by 16-bit non-volatile memory model may run. A serial front end hands it one command per strobe, as an opcode class and an address, together with the two enable pins sampled while that command was loaded. One cycle later the block raises exactly one of `allow` or `abort`. The serial shifter and the self-timed programming engine act only on commands that are allowed.

The block holds four pieces of state:

- a programming-enable flag;
- a one-shot arming flag for protect-register commands;
- a stored threshold address with a separate "cleared" flag;
- a permanent lock flag.

When the threshold is in force, every word at or above it is shielded from single-word erase and write. Bulk erase and bulk write are refused outright. Changing the threshold needs an arming command in the slot immediately before. The lock command freezes the threshold until the whole model is reset. The stored threshold is always visible on `thr_rd`.

Top module: `wpg_top`

## Requirements
- R1: After reset `allow` and `abort` are low, `thr_rd` reads all ones (cleared state), programming is disabled, and nothing is armed or locked.
- R2: Pin rules depend on the class group.
  - Classes 0 to 6 are normal commands and are aborted unless `pin_prot` is low: 0 read, 1 program-on, 2 program-off, 3 erase, 4 write, 5 erase-all, 6 write-all.
  - Classes 7 to 11 are protect-register commands and are aborted unless `pin_prot` is high: 7 threshold-read, 8 arm, 9 clear, 10 set-threshold, 11 lock.
  - Classes 12 to 15 are always aborted.
- R3: Program-on (class 1) is allowed only with `pin_prog` high, and it enables programming. Program-off (class 2) is always allowed on the pin rule and disables programming. The state persists between these two commands.
- R4: The programming commands are classes 3, 4, 5 and 6. Each of them is aborted while programming is disabled or while `pin_prog` is low.
- R5: While the threshold is in force (not cleared), an erase or write whose address is greater than or equal to the threshold is aborted. Below the threshold it is allowed.
- R6: Erase-all and write-all are allowed only while the protect register is in the cleared state.
- R7: Arm (class 8) is allowed only while programming is enabled and both `pin_prot` and `pin_prog` are high.
- R8: The arming flag is consumed by whatever command comes next, accepted or not. Clear, set-threshold and lock each need an accepted arm as the immediately previous command, plus `pin_prog` high.
- R9: Set-threshold stores the address and leaves the cleared state. It is accepted only while cleared. `thr_rd` shows the stored threshold, or all ones while cleared.
- R10: After an accepted lock, every later clear, set-threshold and lock is aborted until reset.
- R11: Read (class 0) is allowed whether programming is enabled or not.
- R12: The decision appears in the cycle after the strobe, with exactly one of `allow` or `abort` high. Without a strobe, both are low and the state is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_vld | input | 1 | Decoded-command strobe, one cycle per command |
| cmd_cls | input | 4 | Opcode class of the command |
| cmd_addr | input | AW (8) | Word address or threshold operand |
| pin_prot | input | 1 | Protect-register enable pin level during load |
| pin_prog | input | 1 | Program enable pin level during load |
| allow | output | 1 | Command accepted (one-cycle pulse) |
| abort | output | 1 | Command refused (one-cycle pulse) |
| thr_rd | output | AW (8) | Stored threshold, all ones while cleared |

## Verification
The hardest state to reach is a locked threshold, and the rejection of change attempts that follow it. Getting there needs a chain of commands, each gated by the one before it: program-on, arm, set-threshold, arm again, then lock. Every arm must land exactly one strobe before its consumer.

The vector table builds this chain step by step. It also places a read between an arm and a clear, to show that an intervening command cancels the arming. Finally it tries clear, set-threshold and a second lock after the lock has taken hold, and each must abort with `thr_rd` unchanged.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [3:0] {
    CLS_READ      = 4'd0,
    CLS_PROG_ON   = 4'd1,
    CLS_PROG_OFF  = 4'd2,
    CLS_ERASE     = 4'd3,
    CLS_WRITE     = 4'd4,
    CLS_ERASE_ALL = 4'd5,
    CLS_WRITE_ALL = 4'd6,
    CLS_THR_READ  = 4'd7,
    CLS_ARM       = 4'd8,
    CLS_CLEAR     = 4'd9,
    CLS_SET_THR   = 4'd10,
    CLS_LOCK      = 4'd11
  } cls_e;

  localparam int unsigned CLS_W = 4;

  typedef struct packed {
    logic ok;
    logic prog_set;
    logic prog_clr;
    logic arm_set;
    logic thr_clear;
    logic thr_load;
    logic lock_set;
  } verdict_t;
endpackage

// File: rtl/wpg_reset_sync.sv
module wpg_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wpg_decide.sv
module wpg_decide
  import wpg_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [CLS_W-1:0] cls,
  input  logic [AW-1:0]    addr,
  input  logic             pin_prot,
  input  logic             pin_prog,
  input  logic             prog_en,
  input  logic             armed,
  input  logic             cleared,
  input  logic             locked,
  input  logic [AW-1:0]    thr,
  output verdict_t         verdict
);
  logic     is_normal;
  logic     is_protcls;
  logic     pin_ok;
  logic     in_region;
  logic     rule_ok;
  verdict_t effect;

  always_comb begin
    is_normal  = (cls <= CLS_WRITE_ALL);
    is_protcls = (cls >= CLS_THR_READ) && (cls <= CLS_LOCK);
    pin_ok     = (is_normal && !pin_prot) || (is_protcls && pin_prot);
    in_region  = !cleared && (addr >= thr);
  end

  always_comb begin
    rule_ok = 1'b0;
    effect  = '0;
    unique case (cls)
      CLS_READ:      rule_ok = 1'b1;
      CLS_PROG_ON: begin
        rule_ok         = pin_prog;
        effect.prog_set = 1'b1;
      end
      CLS_PROG_OFF: begin
        rule_ok         = 1'b1;
        effect.prog_clr = 1'b1;
      end
      CLS_ERASE,
      CLS_WRITE:     rule_ok = prog_en && pin_prog && !in_region;
      CLS_ERASE_ALL,
      CLS_WRITE_ALL: rule_ok = prog_en && pin_prog && cleared;
      CLS_THR_READ:  rule_ok = 1'b1;
      CLS_ARM: begin
        rule_ok        = prog_en && pin_prog;
        effect.arm_set = 1'b1;
      end
      CLS_CLEAR: begin
        rule_ok          = armed && pin_prog && !locked;
        effect.thr_clear = 1'b1;
      end
      CLS_SET_THR: begin
        rule_ok         = armed && pin_prog && !locked && cleared;
        effect.thr_load = 1'b1;
      end
      CLS_LOCK: begin
        rule_ok         = armed && pin_prog && !locked;
        effect.lock_set = 1'b1;
      end
      default:       rule_ok = 1'b0;
    endcase
  end

  always_comb begin
    verdict    = '0;
    verdict.ok = rule_ok && pin_ok;
    if (verdict.ok) begin
      verdict.prog_set  = effect.prog_set;
      verdict.prog_clr  = effect.prog_clr;
      verdict.arm_set   = effect.arm_set;
      verdict.thr_clear = effect.thr_clear;
      verdict.thr_load  = effect.thr_load;
      verdict.lock_set  = effect.lock_set;
    end
  end
endmodule

// File: rtl/wpg_state.sv
module wpg_state
  import wpg_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_vld,
  input  logic [AW-1:0] cmd_addr,
  input  verdict_t      verdict,
  output logic          prog_en_q,
  output logic          armed_q,
  output logic          cleared_q,
  output logic          locked_q,
  output logic [AW-1:0] thr_q
);
  logic          prog_en_d;
  logic          armed_d;
  logic          cleared_d;
  logic          locked_d;
  logic [AW-1:0] thr_d;
  logic          thr_en;

  always_comb begin
    prog_en_d = prog_en_q;
    armed_d   = armed_q;
    cleared_d = cleared_q;
    locked_d  = locked_q;
    thr_d     = thr_q;
    thr_en    = 1'b0;
    if (cmd_vld) begin
      armed_d = verdict.arm_set;
      if (verdict.prog_set) prog_en_d = 1'b1;
      if (verdict.prog_clr) prog_en_d = 1'b0;
      if (verdict.thr_clear) cleared_d = 1'b1;
      if (verdict.thr_load) begin
        cleared_d = 1'b0;
        thr_d     = cmd_addr;
        thr_en    = 1'b1;
      end
      if (verdict.lock_set) locked_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_en_q <= 1'b0;
      armed_q   <= 1'b0;
      cleared_q <= 1'b1;
      locked_q  <= 1'b0;
    end else begin
      prog_en_q <= prog_en_d;
      armed_q   <= armed_d;
      cleared_q <= cleared_d;
      locked_q  <= locked_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (thr_en) thr_q <= thr_d;
  end
endmodule

// File: rtl/wpg_top.sv
module wpg_top
  import wpg_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic [CLS_W-1:0] cmd_cls,
  input  logic [AW-1:0]    cmd_addr,
  input  logic             pin_prot,
  input  logic             pin_prog,
  output logic             allow,
  output logic             abort,
  output logic [AW-1:0]    thr_rd
);
  logic          rst_sync_n;
  logic          prog_en_q;
  logic          armed_q;
  logic          cleared_q;
  logic          locked_q;
  logic [AW-1:0] thr_q;
  verdict_t      verdict;
  logic          allow_d;
  logic          abort_d;

  wpg_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wpg_decide #(.AW(AW)) u_decide (
    .cls      (cmd_cls),
    .addr     (cmd_addr),
    .pin_prot (pin_prot),
    .pin_prog (pin_prog),
    .prog_en  (prog_en_q),
    .armed    (armed_q),
    .cleared  (cleared_q),
    .locked   (locked_q),
    .thr      (thr_q),
    .verdict  (verdict)
  );

  wpg_state #(.AW(AW)) u_state (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_vld   (cmd_vld),
    .cmd_addr  (cmd_addr),
    .verdict   (verdict),
    .prog_en_q (prog_en_q),
    .armed_q   (armed_q),
    .cleared_q (cleared_q),
    .locked_q  (locked_q),
    .thr_q     (thr_q)
  );

  always_comb begin
    allow_d = cmd_vld && verdict.ok;
    abort_d = cmd_vld && !verdict.ok;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      allow <= 1'b0;
      abort <= 1'b0;
    end else begin
      allow <= allow_d;
      abort <= abort_d;
    end
  end

  assign thr_rd = cleared_q ? {AW{1'b1}} : thr_q;
endmodule

// File: rtl/wpg_chk.sv
module wpg_chk
  import wpg_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_vld,
  input logic [CLS_W-1:0] cmd_cls,
  input logic [AW-1:0]    cmd_addr,
  input logic             pin_prot,
  input logic             allow,
  input logic             abort,
  input logic [AW-1:0]    thr_rd,
  input logic             armed,
  input logic             locked,
  input logic             cleared
);
  p_one_verdict_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> (allow ^ abort));

  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> (!allow && !abort && $stable(thr_rd)));

  p_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && (cmd_cls == CLS_ERASE || cmd_cls == CLS_WRITE) && !cleared
     && cmd_addr >= thr_rd) |=> abort);

  p_bulk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && (cmd_cls == CLS_ERASE_ALL || cmd_cls == CLS_WRITE_ALL) && !cleared)
    |=> abort);

  p_arm_consumed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_cls != CLS_ARM) |=> !armed);

  p_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !armed && (cmd_cls == CLS_CLEAR || cmd_cls == CLS_SET_THR
     || cmd_cls == CLS_LOCK)) |=> abort);

  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_locked_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && locked && (cmd_cls == CLS_CLEAR || cmd_cls == CLS_SET_THR
     || cmd_cls == CLS_LOCK)) |=> abort);

  p_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_cls == CLS_READ && !pin_prot) |=> allow);
endmodule

bind wpg_top wpg_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cmd_vld  (cmd_vld),
  .cmd_cls  (cmd_cls),
  .cmd_addr (cmd_addr),
  .pin_prot (pin_prot),
  .allow    (allow),
  .abort    (abort),
  .thr_rd   (thr_rd),
  .armed    (armed_q),
  .locked   (locked_q),
  .cleared  (cleared_q)
);

// File: tb/tb_wpg_top.sv
module tb_wpg_top;
  localparam int AW = 8;
  localparam int NV = 39;

  logic          clk;
  logic          rst_n;
  logic          cmd_vld;
  logic [3:0]    cmd_cls;
  logic [AW-1:0] cmd_addr;
  logic          pin_prot;
  logic          pin_prog;
  logic          allow;
  logic          abort;
  logic [AW-1:0] thr_rd;

  int checks = 0;
  int errors = 0;

  wpg_top #(.AW(AW)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_vld  (cmd_vld),
    .cmd_cls  (cmd_cls),
    .cmd_addr (cmd_addr),
    .pin_prot (pin_prot),
    .pin_prog (pin_prog),
    .allow    (allow),
    .abort    (abort),
    .thr_rd   (thr_rd)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: class, address, pin_prot, pin_prog, expected allow, expected thr_rd, requirement
  localparam logic [26:0] VEC [0:NV-1] = '{
    {4'd4,  8'h10, 1'b0, 1'b1, 1'b0, 8'hFF, 4'd4},  // R4 write while disabled
    {4'd0,  8'h00, 1'b0, 1'b0, 1'b1, 8'hFF, 4'd11}, // R11 read while disabled
    {4'd0,  8'h00, 1'b1, 1'b0, 1'b0, 8'hFF, 4'd2},  // R2 read with prot pin high
    {4'd1,  8'h00, 1'b0, 1'b0, 1'b0, 8'hFF, 4'd3},  // R3 program-on, prog pin low
    {4'd1,  8'h00, 1'b0, 1'b1, 1'b1, 8'hFF, 4'd3},  // R3 program-on
    {4'd4,  8'hFF, 1'b0, 1'b1, 1'b1, 8'hFF, 4'd5},  // R5 cleared: top word writable
    {4'd5,  8'h00, 1'b0, 1'b1, 1'b1, 8'hFF, 4'd6},  // R6 erase-all while cleared
    {4'd9,  8'hFF, 1'b1, 1'b1, 1'b0, 8'hFF, 4'd8},  // R8 clear without arm
    {4'd8,  8'h00, 1'b1, 1'b0, 1'b0, 8'hFF, 4'd7},  // R7 arm, prog pin low
    {4'd8,  8'h00, 1'b1, 1'b1, 1'b1, 8'hFF, 4'd7},  // R7 arm
    {4'd10, 8'h40, 1'b1, 1'b1, 1'b1, 8'h40, 4'd9},  // R9 set threshold
    {4'd4,  8'h40, 1'b0, 1'b1, 1'b0, 8'h40, 4'd5},  // R5 at threshold
    {4'd4,  8'h3F, 1'b0, 1'b1, 1'b1, 8'h40, 4'd5},  // R5 just below
    {4'd3,  8'hFF, 1'b0, 1'b1, 1'b0, 8'h40, 4'd5},  // R5 erase top word
    {4'd6,  8'h00, 1'b0, 1'b1, 1'b0, 8'h40, 4'd6},  // R6 write-all not cleared
    {4'd8,  8'h00, 1'b1, 1'b1, 1'b1, 8'h40, 4'd7},  // R7 arm
    {4'd0,  8'h00, 1'b0, 1'b0, 1'b1, 8'h40, 4'd11}, // R11 read consumes arm
    {4'd9,  8'hFF, 1'b1, 1'b1, 1'b0, 8'h40, 4'd8},  // R8 arm cancelled
    {4'd8,  8'h00, 1'b1, 1'b1, 1'b1, 8'h40, 4'd7},  // R7 arm
    {4'd10, 8'h20, 1'b1, 1'b1, 1'b0, 8'h40, 4'd9},  // R9 not cleared
    {4'd7,  8'h00, 1'b1, 1'b0, 1'b1, 8'h40, 4'd9},  // R9 threshold read
    {4'd8,  8'h00, 1'b1, 1'b1, 1'b1, 8'h40, 4'd7},  // R7 arm
    {4'd9,  8'hFF, 1'b1, 1'b1, 1'b1, 8'hFF, 4'd8},  // R8 clear
    {4'd8,  8'h00, 1'b1, 1'b1, 1'b1, 8'hFF, 4'd7},  // R7 arm
    {4'd10, 8'h80, 1'b1, 1'b1, 1'b1, 8'h80, 4'd9},  // R9 set threshold
    {4'd8,  8'h00, 1'b1, 1'b1, 1'b1, 8'h80, 4'd7},  // R7 arm
    {4'd11, 8'h00, 1'b1, 1'b1, 1'b1, 8'h80, 4'd10}, // R10 lock
    {4'd8,  8'h00, 1'b1, 1'b1, 1'b1, 8'h80, 4'd7},  // R7 arm
    {4'd9,  8'hFF, 1'b1, 1'b1, 1'b0, 8'h80, 4'd10}, // R10 clear after lock
    {4'd8,  8'h00, 1'b1, 1'b1, 1'b1, 8'h80, 4'd7},  // R7 arm
    {4'd11, 8'h00, 1'b1, 1'b1, 1'b0, 8'h80, 4'd10}, // R10 second lock
    {4'd2,  8'h00, 1'b0, 1'b0, 1'b1, 8'h80, 4'd3},  // R3 program-off
    {4'd4,  8'h10, 1'b0, 1'b1, 1'b0, 8'h80, 4'd4},  // R4 disabled again
    {4'd0,  8'h00, 1'b0, 1'b0, 1'b1, 8'h80, 4'd11}, // R11 read
    {4'd8,  8'h00, 1'b1, 1'b1, 1'b0, 8'h80, 4'd7},  // R7 arm while disabled
    {4'd1,  8'h00, 1'b0, 1'b1, 1'b1, 8'h80, 4'd3},  // R3 program-on
    {4'd3,  8'h7F, 1'b0, 1'b1, 1'b1, 8'h80, 4'd5},  // R5 erase below
    {4'd8,  8'h00, 1'b1, 1'b1, 1'b1, 8'h80, 4'd7},  // R7 arm
    {4'd10, 8'h00, 1'b1, 1'b1, 1'b0, 8'h80, 4'd10}  // R10 set threshold locked
  };

  task automatic chk(input bit cond, input string req, input int act, input int exp_v);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // drive at negedge, decision registered at next posedge, sample at the negedge after
  task automatic issue(input logic [3:0] c, input logic [7:0] a, input logic pr, input logic pg);
    cmd_vld  = 1'b1;
    cmd_cls  = c;
    cmd_addr = a;
    pin_prot = pr;
    pin_prog = pg;
    @(negedge clk);
    cmd_vld  = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cmd_vld = 1'b0; cmd_cls = '0; cmd_addr = '0; pin_prot = 1'b0; pin_prog = 1'b0;
    do_reset();
    // R1 reset state
    chk(!allow && !abort, "R1 outputs", {allow, abort}, 0);
    chk(thr_rd == 8'hFF, "R1 thr_rd", thr_rd, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      issue(v[26:23], v[22:15], v[14], v[13]);
      chk(allow == v[12] && abort == !v[12], $sformatf("R%0d vec %0d", v[3:0], i),
          {allow, abort}, {v[12], !v[12]});
      chk(thr_rd == v[11:4], $sformatf("R%0d vec %0d thr", v[3:0], i), thr_rd, v[11:4]);
    end

    // R12 no strobe: outputs idle, threshold kept
    @(negedge clk);
    chk(!allow && !abort, "R12 idle", {allow, abort}, 0);
    chk(thr_rd == 8'h80, "R12 thr held", thr_rd, 8'h80);

    // R2 undefined class always aborts
    issue(4'd13, 8'h00, 1'b1, 1'b1);
    chk(abort && !allow, "R2 class 13", {allow, abort}, 1);
    issue(4'd14, 8'h00, 1'b0, 1'b1);
    chk(abort && !allow, "R2 class 14", {allow, abort}, 1);

    // R1 reset clears lock, threshold and programming enable
    do_reset();
    chk(thr_rd == 8'hFF, "R1 thr after reset", thr_rd, 8'hFF);
    issue(4'd4, 8'h00, 1'b0, 1'b1);
    chk(abort, "R1 prog disabled after reset", {allow, abort}, 1);
    issue(4'd1, 8'h00, 1'b0, 1'b1);
    issue(4'd8, 8'h00, 1'b1, 1'b1);
    issue(4'd10, 8'h05, 1'b1, 1'b1);
    chk(allow && thr_rd == 8'h05, "R1 lock gone after reset", thr_rd, 8'h05);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule